// File: doc/BRIEF.md
# Paged Packet Buffer Allocator

This block keeps the books for a shared packet memory that is cut into fixed pages. A packet asks for room by giving its length in bytes. The block works out how many pages that length needs and takes them from a free-page bitmap, lowest page numbers first. It chains the pages into a linked list and returns a handle, which is the number of the packet's first page. A later release of that handle puts every page of the packet back in the pool in a single cycle. A chain read port lets a data mover follow a packet from page to page.

Next to the pool, the block keeps one shared receive packet queue and one small transmit queue for each virtual endpoint. An enqueue stores a handle, a length and a status byte. The block then fills in the page count of the record by itself, so the entry that comes back on dequeue is a complete packet header. Moving the data, handling the bus protocol and arbitrating between memory clients are all done elsewhere.

Top module: `pgbuf_mgr`

## Requirements
- R1: After reset every page is free: `free_cnt` equals NPG, `alloc_busy` and `alloc_done` are 0, and no queue result is flagged.
- R2: A request of length L needs max(1, ceil(L/PAGE_BYTES)) pages. With the defaults (128-byte pages) that is 1 page for 0 and for 128 bytes, 2 pages for 129 bytes and 10 pages for 1280 bytes. The count is reported on `alloc_npages` with `alloc_done`.
- R3: Pages are granted lowest-numbered free page first. The handle is the first page. `chain_next` gives, one cycle after `chain_page`, the next page of the same packet, and it gives the page itself for the last page.
- R4: A request longer than MAXP*PAGE_BYTES (1280 bytes) is refused. `alloc_done` and `alloc_err` are both high in the cycle after the request, and no page is taken.
- R5: A request that needs more pages than are free is refused in the same way, and `free_cnt` is unchanged.
- R6: A release of a handle that heads a live packet frees all of that packet's pages in one cycle. A release of a page that is free, or that is not the head of its packet, is ignored.
- R7: `free_cnt` is a registered count. It shows a change to the bitmap one cycle after the change, so it moves two clock edges after a release request.
- R8: The receive queue returns entries in first-in first-out order, up to RXQ_DEPTH entries. Each entry gives handle, length, status and the page count computed as in R2, one cycle after the dequeue request.
- R9: An enqueue to a full receive queue sets `rx_enq_err` and stores nothing. A dequeue from an empty receive queue sets `rx_deq_err`. In both cases the queue contents and their order are unchanged.
- R10: Each transmit endpoint, picked by `tx_enq_ep` or `tx_deq_ep`, has its own first-in first-out queue of TXQ_DEPTH entries, and queues of different endpoints do not affect each other.
- R11: An enqueue to a full transmit queue sets `tx_enq_err`, and a dequeue from an empty one sets `tx_deq_err`. The state of that endpoint's queue is unchanged.
- R12: An allocation request made while `alloc_busy` is high is ignored. It produces no grant and takes no page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Allocation request pulse |
| alloc_len | input | LEN_W | Requested packet length in bytes |
| alloc_busy | output | 1 | Allocation in progress |
| alloc_done | output | 1 | Allocation finished (grant or refusal) |
| alloc_err | output | 1 | Allocation refused |
| alloc_handle | output | PG_W | First page of the granted packet |
| alloc_npages | output | NPW | Pages granted |
| free_cnt | output | CNT_W | Registered free-page count |
| rel_req | input | 1 | Release request pulse |
| rel_handle | input | PG_W | Handle to release |
| chain_page | input | PG_W | Page whose successor is read |
| chain_next | output | PG_W | Successor page (itself if last) |
| rx_enq | input | 1 | Receive enqueue |
| rx_enq_handle | input | PG_W | Enqueued handle |
| rx_enq_len | input | LEN_W | Enqueued length |
| rx_enq_status | input | ST_W | Enqueued status |
| rx_enq_ack | output | 1 | Receive enqueue accepted |
| rx_enq_err | output | 1 | Receive enqueue refused (full) |
| rx_deq | input | 1 | Receive dequeue |
| rx_deq_vld | output | 1 | Receive entry valid |
| rx_deq_err | output | 1 | Receive dequeue refused (empty) |
| rx_deq_handle | output | PG_W | Dequeued handle |
| rx_deq_len | output | LEN_W | Dequeued length |
| rx_deq_npages | output | NPW | Dequeued page count |
| rx_deq_status | output | ST_W | Dequeued status |
| tx_enq | input | 1 | Transmit enqueue |
| tx_enq_ep | input | EP_W | Endpoint for enqueue |
| tx_enq_handle | input | PG_W | Enqueued handle |
| tx_enq_len | input | LEN_W | Enqueued length |
| tx_enq_status | input | ST_W | Enqueued status |
| tx_enq_ack | output | 1 | Transmit enqueue accepted |
| tx_enq_err | output | 1 | Transmit enqueue refused (full) |
| tx_deq | input | 1 | Transmit dequeue |
| tx_deq_ep | input | EP_W | Endpoint for dequeue |
| tx_deq_vld | output | 1 | Transmit entry valid |
| tx_deq_err | output | 1 | Transmit dequeue refused (empty) |
| tx_deq_handle | output | PG_W | Dequeued handle |
| tx_deq_len | output | LEN_W | Dequeued length |
| tx_deq_npages | output | NPW | Dequeued page count |
| tx_deq_status | output | ST_W | Dequeued status |

## Verification
The bench keeps the full 32-page pool, 128-byte pages and the 10-page limit. A short table of requests therefore fills the pool exactly, crossing both the length limit and the free-page limit on the way, and later releases open holes that test the lowest-page-first rule and the chain links. The receive queue is shrunk to 4 entries, and the transmit side to 4 endpoints of 3 entries. With these sizes the full and empty refusals are reached after a few operations, and one endpoint's queue can be filled while another still holds data.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_TAKE,
    PS_SEAL
  } pool_st_e;

  // pages needed for a byte count; an empty packet still holds one page
  function automatic int unsigned pg_pages(input int unsigned len,
                                           input int unsigned pb);
    return (len == 0) ? 1 : (len + pb - 1) / pb;
  endfunction

endpackage

// File: rtl/pgbuf_pool.sv
module pgbuf_pool
  import pgbuf_pkg::*;
#(
  parameter int NPG        = 32,
  parameter int PAGE_BYTES = 128,
  parameter int MAXP       = 10,
  parameter int PG_W       = $clog2(NPG),
  parameter int LEN_W      = $clog2(MAXP * PAGE_BYTES + 1),
  parameter int NPW        = $clog2(MAXP + 1),
  parameter int CNT_W      = $clog2(NPG + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_req,
  input  logic [LEN_W-1:0] alloc_len,
  output logic             alloc_busy,
  output logic             alloc_done,
  output logic             alloc_err,
  output logic [PG_W-1:0]  alloc_handle,
  output logic [NPW-1:0]   alloc_npages,
  output logic [CNT_W-1:0] free_cnt,
  input  logic             rel_req,
  input  logic [PG_W-1:0]  rel_handle,
  input  logic [PG_W-1:0]  chain_page,
  output logic [PG_W-1:0]  chain_next
);

  localparam int MAXLEN = MAXP * PAGE_BYTES;
  localparam logic [LEN_W-1:0] MAXLEN_V = LEN_W'(MAXLEN);

  function automatic logic [CNT_W-1:0] pop(input logic [NPG-1:0] m);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < NPG; i++) c = c + CNT_W'(m[i]);
    return c;
  endfunction

  function automatic logic [PG_W-1:0] lowest(input logic [NPG-1:0] m);
    logic [PG_W-1:0] r;
    r = '0;
    for (int i = NPG - 1; i >= 0; i--) if (m[i]) r = PG_W'(i);
    return r;
  endfunction

  pool_st_e         st;
  logic [NPG-1:0]   free_map;
  logic [PG_W-1:0]  owner [NPG];
  logic [PG_W-1:0]  nxt_mem [NPG];
  logic [NPW-1:0]   remain, npg_r;
  logic [PG_W-1:0]  head, prev;
  logic             first;

  logic [PG_W-1:0]  low_idx;
  logic [CNT_W-1:0] avail;
  logic [NPW-1:0]   need;
  logic             rel_ok;
  logic [NPG-1:0]   rel_mask, take_mask;

  always_comb begin
    low_idx = lowest(free_map);
    avail   = pop(free_map);
    need    = NPW'(pg_pages(32'(alloc_len), PAGE_BYTES));
    rel_ok  = rel_req && !free_map[rel_handle] &&
              (owner[rel_handle] == rel_handle) &&
              !((st != PS_IDLE) && (rel_handle == head));
    for (int i = 0; i < NPG; i++) begin
      rel_mask[i]  = rel_ok && !free_map[i] && (owner[i] == rel_handle);
      take_mask[i] = (st == PS_TAKE) && (low_idx == PG_W'(i));
    end
  end

  assign alloc_busy = (st != PS_IDLE);

  // bitmap, owner table and free count
  always_ff @(posedge clk) begin
    if (rst) begin
      free_map <= '1;
      free_cnt <= CNT_W'(NPG);
      for (int i = 0; i < NPG; i++) owner[i] <= '0;
    end else begin
      free_map <= (free_map & ~take_mask) | rel_mask;
      free_cnt <= avail;
      if (st == PS_TAKE) owner[low_idx] <= first ? low_idx : head;
    end
  end

  // link memory: one write, one registered read per cycle
  always_ff @(posedge clk) begin
    if (st == PS_TAKE && !first) nxt_mem[prev] <= low_idx;
    else if (st == PS_SEAL)      nxt_mem[prev] <= prev;
    chain_next <= nxt_mem[chain_page];
  end

  // allocation sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= PS_IDLE;
      alloc_done   <= 1'b0;
      alloc_err    <= 1'b0;
      alloc_handle <= '0;
      alloc_npages <= '0;
      remain       <= '0;
      npg_r        <= '0;
      head         <= '0;
      prev         <= '0;
      first        <= 1'b0;
    end else begin
      alloc_done <= 1'b0;
      unique case (st)
        PS_IDLE: begin
          if (alloc_req) begin
            if (alloc_len > MAXLEN_V || CNT_W'(need) > avail) begin
              alloc_done   <= 1'b1;
              alloc_err    <= 1'b1;
              alloc_npages <= '0;
            end else begin
              st     <= PS_TAKE;
              remain <= need;
              npg_r  <= need;
              first  <= 1'b1;
            end
          end
        end
        PS_TAKE: begin
          if (first) head <= low_idx;
          prev   <= low_idx;
          first  <= 1'b0;
          remain <= remain - 1'b1;
          if (remain == NPW'(1)) st <= PS_SEAL;
        end
        PS_SEAL: begin
          alloc_done   <= 1'b1;
          alloc_err    <= 1'b0;
          alloc_handle <= head;
          alloc_npages <= npg_r;
          st           <= PS_IDLE;
        end
        default: st <= PS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pgbuf_queue.sv
module pgbuf_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enq,
  input  logic [W-1:0] enq_data,
  input  logic         deq,
  output logic         enq_ack,
  output logic         enq_err,
  output logic         deq_vld,
  output logic         deq_err,
  output logic [W-1:0] deq_data
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          enq_ok, deq_ok;

  assign enq_ok = enq && (cnt != CW'(DEPTH));
  assign deq_ok = deq && (cnt != '0);

  always_ff @(posedge clk) begin
    if (enq_ok) mem[wp] <= enq_data;
    if (deq_ok) deq_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      enq_ack <= 1'b0;
      enq_err <= 1'b0;
      deq_vld <= 1'b0;
      deq_err <= 1'b0;
    end else begin
      enq_ack <= enq_ok;
      enq_err <= enq && !enq_ok;
      deq_vld <= deq_ok;
      deq_err <= deq && !deq_ok;
      if (enq_ok) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (deq_ok) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(enq_ok) - CW'(deq_ok);
    end
  end

endmodule

// File: rtl/pgbuf_mgr.sv
module pgbuf_mgr
  import pgbuf_pkg::*;
#(
  parameter int NPG        = 32,
  parameter int PAGE_BYTES = 128,
  parameter int MAXP       = 10,
  parameter int RXQ_DEPTH  = 32,
  parameter int TXQ_DEPTH  = 5,
  parameter int NUM_EP     = 16,
  parameter int ST_W       = 8,
  parameter int PG_W       = $clog2(NPG),
  parameter int LEN_W      = $clog2(MAXP * PAGE_BYTES + 1),
  parameter int NPW        = $clog2(MAXP + 1),
  parameter int CNT_W      = $clog2(NPG + 1),
  parameter int EP_W       = $clog2(NUM_EP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_req,
  input  logic [LEN_W-1:0] alloc_len,
  output logic             alloc_busy,
  output logic             alloc_done,
  output logic             alloc_err,
  output logic [PG_W-1:0]  alloc_handle,
  output logic [NPW-1:0]   alloc_npages,
  output logic [CNT_W-1:0] free_cnt,
  input  logic             rel_req,
  input  logic [PG_W-1:0]  rel_handle,
  input  logic [PG_W-1:0]  chain_page,
  output logic [PG_W-1:0]  chain_next,
  input  logic             rx_enq,
  input  logic [PG_W-1:0]  rx_enq_handle,
  input  logic [LEN_W-1:0] rx_enq_len,
  input  logic [ST_W-1:0]  rx_enq_status,
  output logic             rx_enq_ack,
  output logic             rx_enq_err,
  input  logic             rx_deq,
  output logic             rx_deq_vld,
  output logic             rx_deq_err,
  output logic [PG_W-1:0]  rx_deq_handle,
  output logic [LEN_W-1:0] rx_deq_len,
  output logic [NPW-1:0]   rx_deq_npages,
  output logic [ST_W-1:0]  rx_deq_status,
  input  logic             tx_enq,
  input  logic [EP_W-1:0]  tx_enq_ep,
  input  logic [PG_W-1:0]  tx_enq_handle,
  input  logic [LEN_W-1:0] tx_enq_len,
  input  logic [ST_W-1:0]  tx_enq_status,
  output logic             tx_enq_ack,
  output logic             tx_enq_err,
  input  logic             tx_deq,
  input  logic [EP_W-1:0]  tx_deq_ep,
  output logic             tx_deq_vld,
  output logic             tx_deq_err,
  output logic [PG_W-1:0]  tx_deq_handle,
  output logic [LEN_W-1:0] tx_deq_len,
  output logic [NPW-1:0]   tx_deq_npages,
  output logic [ST_W-1:0]  tx_deq_status
);

  localparam int EW = PG_W + LEN_W + NPW + ST_W;

  pgbuf_pool #(
    .NPG(NPG), .PAGE_BYTES(PAGE_BYTES), .MAXP(MAXP),
    .PG_W(PG_W), .LEN_W(LEN_W), .NPW(NPW), .CNT_W(CNT_W)
  ) u_pool (
    .clk(clk), .rst(rst),
    .alloc_req(alloc_req), .alloc_len(alloc_len),
    .alloc_busy(alloc_busy), .alloc_done(alloc_done), .alloc_err(alloc_err),
    .alloc_handle(alloc_handle), .alloc_npages(alloc_npages),
    .free_cnt(free_cnt),
    .rel_req(rel_req), .rel_handle(rel_handle),
    .chain_page(chain_page), .chain_next(chain_next)
  );

  // header records: page count filled in from the length
  logic [EW-1:0] rx_in, rx_out, tx_in;
  assign rx_in = {rx_enq_handle, rx_enq_len,
                  NPW'(pg_pages(32'(rx_enq_len), PAGE_BYTES)), rx_enq_status};
  assign tx_in = {tx_enq_handle, tx_enq_len,
                  NPW'(pg_pages(32'(tx_enq_len), PAGE_BYTES)), tx_enq_status};

  pgbuf_queue #(.DEPTH(RXQ_DEPTH), .W(EW)) u_rxq (
    .clk(clk), .rst(rst),
    .enq(rx_enq), .enq_data(rx_in), .deq(rx_deq),
    .enq_ack(rx_enq_ack), .enq_err(rx_enq_err),
    .deq_vld(rx_deq_vld), .deq_err(rx_deq_err), .deq_data(rx_out)
  );
  assign {rx_deq_handle, rx_deq_len, rx_deq_npages, rx_deq_status} = rx_out;

  logic [NUM_EP-1:0] e_ack, e_err, d_vld, d_err;
  logic [EW-1:0]     d_data [NUM_EP];
  logic [EP_W-1:0]   ep_d;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_txq
    pgbuf_queue #(.DEPTH(TXQ_DEPTH), .W(EW)) u_txq (
      .clk(clk), .rst(rst),
      .enq(tx_enq && tx_enq_ep == EP_W'(g)), .enq_data(tx_in),
      .deq(tx_deq && tx_deq_ep == EP_W'(g)),
      .enq_ack(e_ack[g]), .enq_err(e_err[g]),
      .deq_vld(d_vld[g]), .deq_err(d_err[g]), .deq_data(d_data[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) ep_d <= '0;
    else if (tx_deq) ep_d <= tx_deq_ep;
  end

  assign tx_enq_ack = |e_ack;
  assign tx_enq_err = |e_err;
  assign tx_deq_vld = |d_vld;
  assign tx_deq_err = |d_err;
  assign {tx_deq_handle, tx_deq_len, tx_deq_npages, tx_deq_status} = d_data[ep_d];

endmodule

// File: rtl/pgbuf_mgr_chk.sv
module pgbuf_mgr_chk #(
  parameter int NPG        = 32,
  parameter int PAGE_BYTES = 128,
  parameter int MAXP       = 10,
  parameter int LEN_W      = 11,
  parameter int NPW        = 4,
  parameter int CNT_W      = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_req,
  input logic [LEN_W-1:0] alloc_len,
  input logic             alloc_busy,
  input logic             alloc_done,
  input logic             alloc_err,
  input logic [NPW-1:0]   alloc_npages,
  input logic [CNT_W-1:0] free_cnt,
  input logic             rx_enq_ack,
  input logic             rx_enq_err,
  input logic             rx_deq_vld,
  input logic             rx_deq_err,
  input logic             tx_enq_ack,
  input logic             tx_enq_err,
  input logic             tx_deq_vld,
  input logic             tx_deq_err
);

  localparam logic [LEN_W-1:0] MAXLEN_V = LEN_W'(MAXP * PAGE_BYTES);

  assert_long_refused_R4: assert property (@(posedge clk) disable iff (rst)
    (!alloc_busy && alloc_req && alloc_len > MAXLEN_V) |=> (alloc_done && alloc_err));

  assert_grant_size_R2: assert property (@(posedge clk) disable iff (rst)
    (alloc_done && !alloc_err) |-> (alloc_npages >= NPW'(1) && alloc_npages <= NPW'(MAXP)));

  assert_free_bound_R7: assert property (@(posedge clk) disable iff (rst)
    free_cnt <= CNT_W'(NPG));

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (rst)
    alloc_done |-> !alloc_busy);

  assert_rx_enq_excl_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_enq_ack, rx_enq_err}));

  assert_rx_deq_excl_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_deq_vld, rx_deq_err}));

  assert_tx_excl_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_enq_ack, tx_enq_err}) && $onehot0({tx_deq_vld, tx_deq_err}));

endmodule

bind pgbuf_mgr pgbuf_mgr_chk #(
  .NPG(NPG), .PAGE_BYTES(PAGE_BYTES), .MAXP(MAXP),
  .LEN_W(LEN_W), .NPW(NPW), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst),
  .alloc_req(alloc_req), .alloc_len(alloc_len),
  .alloc_busy(alloc_busy), .alloc_done(alloc_done), .alloc_err(alloc_err),
  .alloc_npages(alloc_npages), .free_cnt(free_cnt),
  .rx_enq_ack(rx_enq_ack), .rx_enq_err(rx_enq_err),
  .rx_deq_vld(rx_deq_vld), .rx_deq_err(rx_deq_err),
  .tx_enq_ack(tx_enq_ack), .tx_enq_err(tx_enq_err),
  .tx_deq_vld(tx_deq_vld), .tx_deq_err(tx_deq_err)
);

// File: tb/sim_pgbuf_mgr.sv
module sim_pgbuf_mgr;

  localparam int NPG = 32, PB = 128, MAXP = 10, RXQ = 4, TXQ = 3, NEP = 4, ST_W = 8;
  localparam int PG_W = 5, LEN_W = 11, NPW = 4, CNT_W = 6, EP_W = 2;

  logic clk = 0, rst = 1;
  always #2.5 clk = ~clk;

  logic             alloc_req = 0, rel_req = 0;
  logic [LEN_W-1:0] alloc_len = '0;
  logic             alloc_busy, alloc_done, alloc_err;
  logic [PG_W-1:0]  alloc_handle, rel_handle = '0, chain_page = '0, chain_next;
  logic [NPW-1:0]   alloc_npages;
  logic [CNT_W-1:0] free_cnt;
  logic             rx_enq = 0, rx_deq = 0, rx_enq_ack, rx_enq_err, rx_deq_vld, rx_deq_err;
  logic [PG_W-1:0]  rx_enq_handle = '0, rx_deq_handle;
  logic [LEN_W-1:0] rx_enq_len = '0, rx_deq_len;
  logic [ST_W-1:0]  rx_enq_status = '0, rx_deq_status;
  logic [NPW-1:0]   rx_deq_npages;
  logic             tx_enq = 0, tx_deq = 0, tx_enq_ack, tx_enq_err, tx_deq_vld, tx_deq_err;
  logic [EP_W-1:0]  tx_enq_ep = '0, tx_deq_ep = '0;
  logic [PG_W-1:0]  tx_enq_handle = '0, tx_deq_handle;
  logic [LEN_W-1:0] tx_enq_len = '0, tx_deq_len;
  logic [ST_W-1:0]  tx_enq_status = '0, tx_deq_status;
  logic [NPW-1:0]   tx_deq_npages;

  pgbuf_mgr #(.NPG(NPG), .PAGE_BYTES(PB), .MAXP(MAXP), .RXQ_DEPTH(RXQ),
              .TXQ_DEPTH(TXQ), .NUM_EP(NEP), .ST_W(ST_W)) u0 (.*);

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {len, err, handle, npages, free after}
  localparam logic [26:0] VEC [10] = '{
    {11'd0,    1'b0, 5'd0,  4'd1,  6'd31},
    {11'd128,  1'b0, 5'd1,  4'd1,  6'd30},
    {11'd129,  1'b0, 5'd2,  4'd2,  6'd28},
    {11'd1280, 1'b0, 5'd4,  4'd10, 6'd18},
    {11'd1281, 1'b1, 5'd0,  4'd0,  6'd18},
    {11'd640,  1'b0, 5'd14, 4'd5,  6'd13},
    {11'd1000, 1'b0, 5'd19, 4'd8,  6'd5},
    {11'd768,  1'b1, 5'd0,  4'd0,  6'd5},
    {11'd600,  1'b0, 5'd27, 4'd5,  6'd0},
    {11'd0,    1'b1, 5'd0,  4'd0,  6'd0}
  };

  task automatic do_alloc(input int len);
    @(negedge clk); alloc_req = 1; alloc_len = LEN_W'(len);
    @(negedge clk); alloc_req = 0;
    for (int k = 0; k < 40 && !alloc_done; k++) @(negedge clk);
  endtask

  task automatic do_rel(input int h);
    @(negedge clk); rel_req = 1; rel_handle = PG_W'(h);
    @(negedge clk); rel_req = 0;
    @(negedge clk);
  endtask

  task automatic do_chain(input int p, input int exp, input string req);
    @(negedge clk); chain_page = PG_W'(p);
    @(negedge clk); chk(req, chain_next, exp);
  endtask

  task automatic rx_put(input int h, input int l, input int s, input int exp_err);
    @(negedge clk); rx_enq = 1; rx_enq_handle = PG_W'(h); rx_enq_len = LEN_W'(l); rx_enq_status = ST_W'(s);
    @(negedge clk); rx_enq = 0;
    chk(exp_err ? "R9 rx full err" : "R8 rx enq ack", exp_err ? rx_enq_err : rx_enq_ack, 1);
  endtask

  task automatic rx_get(input int h, input int l, input int np, input int s);
    @(negedge clk); rx_deq = 1;
    @(negedge clk); rx_deq = 0;
    chk("R8 rx vld", rx_deq_vld, 1);
    chk("R8 rx handle", rx_deq_handle, h);
    chk("R8 rx len", rx_deq_len, l);
    chk("R8 rx npages", rx_deq_npages, np);
    chk("R8 rx status", rx_deq_status, s);
  endtask

  task automatic tx_put(input int ep, input int h, input int l, input int s, input int exp_err);
    @(negedge clk); tx_enq = 1; tx_enq_ep = EP_W'(ep); tx_enq_handle = PG_W'(h);
    tx_enq_len = LEN_W'(l); tx_enq_status = ST_W'(s);
    @(negedge clk); tx_enq = 0;
    chk(exp_err ? "R11 tx full err" : "R10 tx enq ack", exp_err ? tx_enq_err : tx_enq_ack, 1);
  endtask

  task automatic tx_get(input int ep, input int h, input int l, input int np, input int s);
    @(negedge clk); tx_deq = 1; tx_deq_ep = EP_W'(ep);
    @(negedge clk); tx_deq = 0;
    chk("R10 tx vld", tx_deq_vld, 1);
    chk("R10 tx handle", tx_deq_handle, h);
    chk("R10 tx len", tx_deq_len, l);
    chk("R10 tx npages", tx_deq_npages, np);
    chk("R10 tx status", tx_deq_status, s);
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 free_cnt", free_cnt, 32);
    chk("R1 busy", alloc_busy, 0);
    chk("R1 done", alloc_done, 0);
    chk("R1 rx ack", rx_enq_ack, 0);

    // R2 R3 R4 R5: vector walk over a fresh pool
    for (int v = 0; v < 10; v++) begin
      do_alloc(int'(VEC[v][26:16]));
      chk("R2 done", alloc_done, 1);
      chk(VEC[v][15] ? "R4 R5 refusal" : "R3 grant", alloc_err, int'(VEC[v][15]));
      if (!VEC[v][15]) begin
        chk("R3 handle", alloc_handle, int'(VEC[v][14:10]));
        chk("R2 npages", alloc_npages, int'(VEC[v][9:6]));
      end
      chk("R5 free_cnt", free_cnt, int'(VEC[v][5:0]));
    end

    do_chain(2, 3, "R3 chain link");
    do_chain(3, 3, "R3 chain end");

    // R6 R7 release
    @(negedge clk); rel_req = 1; rel_handle = 5'd4;
    @(negedge clk); rel_req = 0;
    chk("R7 free_cnt lag", free_cnt, 0);
    @(negedge clk);
    chk("R6 release all pages", free_cnt, 10);

    do_alloc(300);
    chk("R3 reuse handle", alloc_handle, 4);
    chk("R2 npages 300", alloc_npages, 3);
    chk("R5 free after", free_cnt, 7);
    do_chain(4, 5, "R3 chain 4");
    do_chain(5, 6, "R3 chain 5");
    do_chain(6, 6, "R3 chain 6 end");

    do_rel(5);
    chk("R6 non-head ignored", free_cnt, 7);
    do_rel(0);
    chk("R6 single page", free_cnt, 8);
    do_rel(0);
    chk("R6 free page ignored", free_cnt, 8);

    // R12 request during busy
    @(negedge clk); alloc_req = 1; alloc_len = 11'd256;
    @(negedge clk); alloc_len = 11'd1280;
    chk("R12 busy", alloc_busy, 1);
    @(negedge clk); alloc_req = 0;
    for (int k = 0; k < 40 && !alloc_done; k++) @(negedge clk);
    chk("R12 handle", alloc_handle, 0);
    chk("R12 npages", alloc_npages, 2);
    begin
      int extra = 0;
      for (int k = 0; k < 15; k++) begin @(negedge clk); if (alloc_done) extra++; end
      chk("R12 no second grant", extra, 0);
    end
    chk("R12 free_cnt", free_cnt, 6);
    do_chain(0, 7, "R3 hole fill");
    do_chain(7, 7, "R3 hole end");

    do_alloc(1000);
    chk("R5 too few pages", alloc_err, 1);
    @(negedge clk);
    chk("R5 free kept", free_cnt, 6);

    // R8 R9 receive queue
    @(negedge clk); rx_deq = 1;
    @(negedge clk); rx_deq = 0;
    chk("R9 empty deq err", rx_deq_err, 1);
    rx_put(3, 0, 8'h11, 0);
    rx_put(7, 129, 8'h22, 0);
    rx_put(9, 1280, 8'h33, 0);
    rx_put(12, 640, 8'h44, 0);
    rx_put(1, 1, 8'h55, 1);
    rx_get(3, 0, 1, 8'h11);
    rx_get(7, 129, 2, 8'h22);
    rx_get(9, 1280, 10, 8'h33);
    rx_get(12, 640, 5, 8'h44);
    @(negedge clk); rx_deq = 1;
    @(negedge clk); rx_deq = 0;
    chk("R9 drained deq err", rx_deq_err, 1);

    // R10 R11 transmit queues
    tx_put(2, 5, 200, 8'hA1, 0);
    tx_put(0, 6, 10, 8'hB0, 0);
    tx_put(0, 8, 300, 8'hB1, 0);
    tx_put(0, 10, 384, 8'hB2, 0);
    tx_put(0, 11, 1, 8'hB3, 1);
    tx_get(2, 5, 200, 2, 8'hA1);
    tx_get(0, 6, 10, 1, 8'hB0);
    tx_get(0, 8, 300, 3, 8'hB1);
    tx_get(0, 10, 384, 3, 8'hB2);
    @(negedge clk); tx_deq = 1; tx_deq_ep = 2'd1;
    @(negedge clk); tx_deq = 0;
    chk("R11 empty ep1", tx_deq_err, 1);
    @(negedge clk); tx_deq = 1; tx_deq_ep = 2'd0;
    @(negedge clk); tx_deq = 0;
    chk("R11 empty ep0", tx_deq_err, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule